// File: doc/BRIEF.md
# Removable Key Power Sequencer

This block brings a removable memory key onto a host's serial bus safely. It watches one presence contact, which is active low and is the last contact to mate and the first to break. The sequencer checks that the contact has stayed closed for a whole settle window. It then switches on the key supply and the signal pull-up supply together. It waits out a stabilise window and hands the bus to the host only if the key is still present at the end of it.

While the bus is granted, the host marks each transfer with a begin pulse, which carries a write/read flag, and an end pulse. The block confirms each clean finish with a one-cycle acknowledge. If the key leaves while it is powered, both supplies drop and the grant is withdrawn, and the sequencer goes back to waiting for an insertion. A removal during a transfer is reported with a code that tells a lost write from a lost read.

An activity output follows the grant so that an indicator can warn the user not to pull the key. A phase output shows the sequencer's current step.

Top module: `keypwr_seq`

## Requirements
- R1: After reset, `phase` is 0 (empty), `loss_code` is 0, and `key_pwr_en`, `key_pullup_en`, `bus_grant`, `activity` and `acc_ok` are all low.
- R2: `key_present_n` low means a key is inserted. The input passes through a two-stage synchroniser. If it is held low continuously, both supply enables rise on the (SETTLE_CYC+3)-th rising clock edge after it falls, and `phase` becomes 2 (stabilise). One edge earlier, both enables are still low.
- R3: If presence is lost during the settle window, the sequencer returns to phase 0 and the settle count restarts. Power then comes on SETTLE_CYC+3 edges after the last falling edge of `key_present_n`.
- R4: `key_pwr_en` and `key_pullup_en` always carry the same value. Neither is ever high without the other.
- R5: `bus_grant` and `activity` rise together exactly STAB_CYC edges after the supply enables rise, with `phase` 3 (ready), provided presence holds until then. Both are high only in phases 3, 4 and 5.
- R6: `acc_begin` sampled high in phase 3 moves the sequencer to phase 5 (write) if `acc_write` is 1, or to phase 4 (read) if it is 0, and clears `loss_code` to 0. In any other phase, `acc_begin` is ignored.
- R7: `acc_end` sampled high in phase 4 or 5 while the key is present returns the sequencer to phase 3 and raises `acc_ok` for exactly one cycle. In phase 3, `acc_end` is ignored and `acc_ok` stays low.
- R8: If `key_present_n` rises while the key is powered (phases 2 to 5), the sequencer is in phase 0 by the third rising edge after the rise, with both supplies, `bus_grant` and `activity` low.
- R9: A removal in phase 4 sets `loss_code` to 1 (read lost). A removal in phase 5 sets it to 2 (write lost). The code holds until the next accepted `acc_begin`, and a removal in phases 1 to 3 leaves it unchanged.
- R10: If `acc_end` for a write arrives when the synchronised presence already shows the key gone, no `acc_ok` is given and `loss_code` becomes 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_present_n | input | 1 | Raw presence contact, low when a key is inserted |
| acc_begin | input | 1 | Host pulse: a transfer starts |
| acc_write | input | 1 | Transfer type for `acc_begin`: 1 write, 0 read |
| acc_end | input | 1 | Host pulse: the transfer has finished |
| key_pwr_en | output | 1 | Key supply enable |
| key_pullup_en | output | 1 | Signal pull-up supply enable |
| bus_grant | output | 1 | The host may drive the key bus |
| activity | output | 1 | Indicator drive: removal is unsafe |
| acc_ok | output | 1 | One-cycle confirmation of a clean transfer end |
| loss_code | output | 2 | 0 none, 1 key lost during a read, 2 key lost during a write |
| phase | output | 3 | 0 empty, 1 settle, 2 stabilise, 3 ready, 4 read, 5 write |

## Verification
The bench builds the sequencer with SETTLE_CYC = 8 and STAB_CYC = 12, down from counts sized for real settle and power-up times. With these values, every edge of both windows can be checked exactly: the last cycle with power off, the first with power on, and the first with the grant. Bounces and removals in the middle of each window, and in the middle of each transfer type, also stay within a few dozen cycles.

// File: rtl/keypwr_pkg.sv
package keypwr_pkg;

  typedef enum logic [2:0] {
    PH_EMPTY  = 3'd0,
    PH_SETTLE = 3'd1,
    PH_STAB   = 3'd2,
    PH_READY  = 3'd3,
    PH_READ   = 3'd4,
    PH_WRITE  = 3'd5
  } phase_t;

  typedef enum logic [1:0] {
    LOSS_NONE  = 2'd0,
    LOSS_READ  = 2'd1,
    LOSS_WRITE = 2'd2
  } loss_t;

  // counter width able to hold values 0 .. limit-1
  function automatic int cnt_w(input int limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

  function automatic logic is_powered(input phase_t p);
    return (p == PH_STAB) || (p == PH_READY) || (p == PH_READ) || (p == PH_WRITE);
  endfunction

  function automatic logic is_granted(input phase_t p);
    return (p == PH_READY) || (p == PH_READ) || (p == PH_WRITE);
  endfunction

  function automatic logic in_xfer(input phase_t p);
    return (p == PH_READ) || (p == PH_WRITE);
  endfunction

  function automatic loss_t loss_for(input phase_t p);
    case (p)
      PH_READ:  return LOSS_READ;
      PH_WRITE: return LOSS_WRITE;
      default:  return LOSS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/keypwr_sync.sv
module keypwr_sync #(
  parameter int  STAGES    = 2,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[gi] <= RST_VAL;
          else        chain_q[gi] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[gi] <= RST_VAL;
          else        chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/keypwr_timer.sv
module keypwr_timer #(
  parameter int LIMIT = 8,
  localparam int W = keypwr_pkg::cnt_w(LIMIT)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic hit
);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign hit = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  // R3: count never passes the window end, and a stop clears it
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  a_r3_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/keypwr_fsm.sv
module keypwr_fsm
  import keypwr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pres,
  input  logic   settle_hit,
  input  logic   stab_hit,
  input  logic   acc_begin,
  input  logic   acc_write,
  input  logic   acc_end,
  output phase_t phase_q,
  output logic   acc_ok_q,
  output loss_t  loss_q
);
  phase_t phase_d;
  loss_t  loss_d;
  logic   ok_d;

  // named internal events
  logic loss_evt, start_evt, finish_evt;

  assign loss_evt   = is_powered(phase_q) && !pres;
  assign start_evt  = (phase_q == PH_READY) && pres && acc_begin;
  assign finish_evt = in_xfer(phase_q) && pres && acc_end;

  always_comb begin
    phase_d = phase_q;
    loss_d  = loss_q;
    ok_d    = 1'b0;
    case (phase_q)
      PH_EMPTY:  if (pres) phase_d = PH_SETTLE;
      PH_SETTLE: begin
        if (!pres)           phase_d = PH_EMPTY;
        else if (settle_hit) phase_d = PH_STAB;
      end
      PH_STAB: begin
        if (!pres)         phase_d = PH_EMPTY;
        else if (stab_hit) phase_d = PH_READY;
      end
      PH_READY: begin
        if (!pres) phase_d = PH_EMPTY;
        else if (start_evt) begin
          phase_d = acc_write ? PH_WRITE : PH_READ;
          loss_d  = LOSS_NONE;
        end
      end
      PH_READ, PH_WRITE: begin
        if (loss_evt) begin
          phase_d = PH_EMPTY;
          loss_d  = loss_for(phase_q);
        end else if (finish_evt) begin
          phase_d = PH_READY;
          ok_d    = 1'b1;
        end
      end
      default: phase_d = PH_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= PH_EMPTY;
      loss_q   <= LOSS_NONE;
      acc_ok_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      loss_q   <= loss_d;
      acc_ok_q <= ok_d;
    end
  end

  // R8: a powered key that leaves lands in the empty phase next cycle
  a_r8_loss_to_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (is_powered(phase_q) && !pres) |=> phase_q == PH_EMPTY);
  // R2: power phase is entered only from a full settle window with presence
  a_r2_power_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_STAB && $past(phase_q) != PH_STAB) |-> $past(settle_hit && pres));
  // R5: grant phase entered only when the stabilise window has elapsed
  a_r5_grant_after_stab: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_READY && $past(phase_q) == PH_STAB) |-> $past(stab_hit));
  // R7: confirmation follows a present end pulse and lasts one cycle
  a_r7_ok_source: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok_q |-> $past(pres && acc_end && in_xfer(phase_q)));
  a_r7_ok_single: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok_q |=> !acc_ok_q);
  // R9: a new loss code appears only out of a transfer phase
  a_r9_loss_from_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (loss_q != LOSS_NONE && loss_q != $past(loss_q)) |-> $past(in_xfer(phase_q)));
  // R6: transfer phases are entered only from the ready phase
  a_r6_xfer_from_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer(phase_q) && !in_xfer($past(phase_q))) |-> $past(phase_q) == PH_READY);
endmodule

// File: rtl/keypwr_seq.sv
module keypwr_seq
  import keypwr_pkg::*;
#(
  parameter int SETTLE_CYC = 50000,
  parameter int STAB_CYC   = 131072,
  parameter int SYNC_STG   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_present_n,
  input  logic       acc_begin,
  input  logic       acc_write,
  input  logic       acc_end,
  output logic       key_pwr_en,
  output logic       key_pullup_en,
  output logic       bus_grant,
  output logic       activity,
  output logic       acc_ok,
  output logic [1:0] loss_code,
  output logic [2:0] phase
);
  logic   present_n_s, pres;
  logic   settle_hit, stab_hit;
  phase_t phase_q;
  loss_t  loss_q;
  logic   ok_q;

  keypwr_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(key_present_n), .q_sync(present_n_s)
  );

  assign pres = ~present_n_s;

  keypwr_timer #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .run(phase_q == PH_SETTLE), .hit(settle_hit)
  );

  keypwr_timer #(.LIMIT(STAB_CYC)) u_stab (
    .clk(clk), .rst_n(rst_n), .run(phase_q == PH_STAB), .hit(stab_hit)
  );

  keypwr_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pres(pres),
    .settle_hit(settle_hit), .stab_hit(stab_hit),
    .acc_begin(acc_begin), .acc_write(acc_write), .acc_end(acc_end),
    .phase_q(phase_q), .acc_ok_q(ok_q), .loss_q(loss_q)
  );

  assign key_pwr_en    = is_powered(phase_q);
  assign key_pullup_en = is_powered(phase_q);
  assign bus_grant     = is_granted(phase_q);
  assign activity      = is_granted(phase_q);
  assign acc_ok        = ok_q;
  assign loss_code     = loss_q;
  assign phase         = phase_q;

  // R5: grant only with both supplies on
  a_r5_grant_powered: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant |-> (key_pwr_en && key_pullup_en));
  // R4: supplies rise only out of the settle phase
  a_r4_rise_from_settle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_pwr_en) |-> $past(phase_q) == PH_SETTLE);
endmodule

// File: tb/keypwr_seq_bench.sv
module keypwr_seq_bench;
  localparam int SET = 8;
  localparam int STB = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_present_n = 1'b1;
  logic acc_begin = 1'b0, acc_write = 1'b0, acc_end = 1'b0;
  logic key_pwr_en, key_pullup_en, bus_grant, activity, acc_ok;
  logic [1:0] loss_code;
  logic [2:0] phase;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  keypwr_seq #(.SETTLE_CYC(SET), .STAB_CYC(STB)) u_keypwr_seq (
    .clk(clk), .rst_n(rst_n), .key_present_n(key_present_n),
    .acc_begin(acc_begin), .acc_write(acc_write), .acc_end(acc_end),
    .key_pwr_en(key_pwr_en), .key_pullup_en(key_pullup_en),
    .bus_grant(bus_grant), .activity(activity), .acc_ok(acc_ok),
    .loss_code(loss_code), .phase(phase)
  );

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_supplies(input string req, input int exp);
    chk(req, int'(key_pwr_en), exp);
    chk(req, int'(key_pullup_en), exp);
  endtask

  task automatic t_reset;
    chk("R1 phase", int'(phase), 0);
    chk("R1 loss", int'(loss_code), 0);
    chk_supplies("R1 supplies", 0);
    chk("R1 grant", int'(bus_grant), 0);
    chk("R1 activity", int'(activity), 0);
    chk("R1 ok", int'(acc_ok), 0);
  endtask

  // full insertion with exact edge checks of both windows
  task automatic t_insert;
    key_present_n = 1'b0;
    tick(SET + 2);
    chk_supplies("R2 off before settle end", 0);
    tick(1);
    chk_supplies("R2 on at settle end", 1);
    chk("R4 pullup with power", int'(key_pullup_en), int'(key_pwr_en));
    chk("R2 phase stab", int'(phase), 2);
    chk("R5 no early grant", int'(bus_grant), 0);
    tick(STB - 1);
    chk("R5 grant still low", int'(bus_grant), 0);
    tick(1);
    chk("R5 grant", int'(bus_grant), 1);
    chk("R5 activity", int'(activity), 1);
    chk("R5 phase ready", int'(phase), 3);
  endtask

  task automatic t_remove_idle(input string req);
    key_present_n = 1'b1;
    tick(3);
    chk(req, int'(phase), 0);
    chk_supplies(req, 0);
    chk(req, int'(bus_grant), 0);
    tick(2);
  endtask

  task automatic t_bounce;
    key_present_n = 1'b0;
    tick(3);
    chk("R3 settling", int'(phase), 1);
    key_present_n = 1'b1;
    tick(2);
    key_present_n = 1'b0;
    tick(SET + 2);
    chk_supplies("R3 restart holds power off", 0);
    tick(1);
    chk_supplies("R3 power after restart", 1);
    tick(STB);
    chk("R3 ready after restart", int'(phase), 3);
  endtask

  task automatic t_xfer(input bit wr);
    acc_begin = 1'b1; acc_write = wr;
    tick(1);
    acc_begin = 1'b0; acc_write = 1'b0;
    chk("R6 xfer phase", int'(phase), wr ? 5 : 4);
    chk("R6 loss cleared", int'(loss_code), 0);
    tick(2);
    chk("R7 no ok mid xfer", int'(acc_ok), 0);
    acc_end = 1'b1;
    tick(1);
    acc_end = 1'b0;
    chk("R7 ok pulse", int'(acc_ok), 1);
    chk("R7 back ready", int'(phase), 3);
    tick(1);
    chk("R7 ok one cycle", int'(acc_ok), 0);
  endtask

  task automatic t_ignored;
    acc_end = 1'b1;
    tick(1);
    acc_end = 1'b0;
    chk("R7 end ignored in ready", int'(acc_ok), 0);
    chk("R7 phase kept", int'(phase), 3);
  endtask

  task automatic t_lose_read;
    acc_begin = 1'b1; acc_write = 1'b0;
    tick(1);
    acc_begin = 1'b0;
    key_present_n = 1'b1;
    tick(2);
    chk("R8 still powered", int'(key_pwr_en), 1);
    tick(1);
    chk("R8 phase empty", int'(phase), 0);
    chk_supplies("R8 supplies off", 0);
    chk("R8 grant off", int'(bus_grant), 0);
    chk("R8 activity off", int'(activity), 0);
    chk("R9 read lost", int'(loss_code), 1);
    tick(2);
  endtask

  task automatic t_lose_write_end;
    acc_begin = 1'b1; acc_write = 1'b1;
    tick(1);
    acc_begin = 1'b0; acc_write = 1'b0;
    key_present_n = 1'b1;
    tick(2);
    acc_end = 1'b1;
    tick(1);
    acc_end = 1'b0;
    chk("R10 no ok", int'(acc_ok), 0);
    chk("R10 write lost", int'(loss_code), 2);
    chk("R10 phase empty", int'(phase), 0);
    tick(2);
  endtask

  task automatic t_stab_loss_and_begin;
    key_present_n = 1'b0;
    tick(SET + 3);
    chk("R6 in stab", int'(phase), 2);
    acc_begin = 1'b1; acc_write = 1'b1;
    tick(1);
    acc_begin = 1'b0; acc_write = 1'b0;
    chk("R6 begin ignored in stab", int'(phase), 2);
    key_present_n = 1'b1;
    tick(3);
    chk("R8 stab loss empty", int'(phase), 0);
    chk_supplies("R8 stab loss off", 0);
    chk("R9 code kept", int'(loss_code), 2);
    tick(2);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin : main
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_insert();
    t_ignored();
    t_xfer(1'b0);
    t_xfer(1'b1);
    t_remove_idle("R8 removal in ready");
    t_bounce();
    t_lose_read();
    t_insert();
    t_lose_write_end();
    t_stab_loss_and_begin();
    t_insert();
    t_xfer(1'b0);
    t_remove_idle("R9 removal in ready");
    chk("R9 code cleared by begin stays", int'(loss_code), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule